// File: doc/BRIEF.md
# Counter Machine Executor

This block runs short programs for a three-register counter machine. Each register holds an unsigned count. A program is a numbered list of steps. Every step either increments a register, decrements a register or takes a branch when that register is empty, or stops. There is no sequential program counter: each step names the step that follows it, and the decrement step names a second target that is taken when its register is already zero.

While the machine is idle, software-side logic writes steps into a 16-slot program store and may preset any of the three registers. A one-cycle start pulse begins execution at step 1. The block executes one step per clock. When it reaches a stop step, jumps somewhere it cannot execute, or meets a malformed step, it raises done. The register values stay on the output ports until the next start. A step counter reports how many cycles the run took.

Top module: `cm_exec`

## Requirements
- R1: A step word is 12 bits: bits [11:10] opcode (00 stop, 01 increment, 10 decrement-or-branch, 11 illegal), bits [9:8] register number (1, 2 or 3), bits [7:4] next step, bits [3:0] branch step. An illegal opcode, or register number 0 on an increment or decrement, halts the run with err set.
- R2: Program writes (prog_we) and register presets (preset_we) take effect only while busy is low. Writes to slot 0 are ignored.
- R3: Increment adds one to the named register and continues at the next step. At 255 the register stays at 255 and the sticky ovf flag is set. ovf is cleared by reset and by every accepted start.
- R4: Decrement on a non-zero register subtracts one and continues at the next step. On a zero register it leaves the register unchanged and continues at the branch step.
- R5: A start pulse while busy is low is accepted at that clock edge: busy is high from the next cycle, and execution begins at step 1 with one step per clock.
- R6: A stop step ends the run: from the following cycle done is 1, busy is 0, and the registers hold their values until a new start or preset. An accepted start clears done and err.
- R7: Executing step 0, a step never written since reset, or a step that R1 declares malformed halts the run with done and err both 1. The faulting step changes no register.
- R8: step_count restarts at 0 on an accepted start and counts every execution cycle, including the final stop or faulting step. done rises exactly step_count clock edges after the start edge.
- R9: Synchronous active-high reset clears the registers, ovf, err, done, step_count and the written marks of all program slots, and returns the block to idle, even in the middle of a run.
- R10: The program "1: dec r3 next 1 branch 2; 2: dec r2 next 3 branch 4; 3: inc r3 next 2; 4: stop" ends with r2 = 0, r3 equal to the starting r2, r1 unchanged, and step_count = r3start + 2*r2start + 3.
- R11: The eight-step copy program (clear r3, clear r2, move r1 into r3 and r2, move r2 back into r1, stop) ends with r1 unchanged, r2 = 0, r3 = starting r1, and step_count = r3start + r2start + 5*r1start + 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program slot write strobe (idle only) |
| prog_addr | input | 4 | Program slot number |
| prog_word | input | 12 | Step word, layout per R1 |
| preset_we | input | 1 | Register preset strobe (idle only) |
| preset_sel | input | 2 | Register number to preset (1..3) |
| preset_val | input | 8 | Preset value |
| start | input | 1 | Begin execution at step 1 |
| busy | output | 1 | A program is executing |
| done | output | 1 | The last run has ended |
| err | output | 1 | The last run ended on a fault |
| ovf | output | 1 | Sticky increment saturation flag |
| reg1 | output | 8 | Register 1 value |
| reg2 | output | 8 | Register 2 value |
| reg3 | output | 8 | Register 3 value |
| step_count | output | 16 | Execution cycles of the current or last run |

## Verification
The start edge is captured by one register, so busy is checked on the falling edge right after it. Each later edge executes exactly one step. The bench therefore counts falling edges until done and requires that count to equal both step_count and the arithmetic count the program formula predicts. Register, ovf and err results are read only once done is high, when they are frozen. The effects of presets, slot writes and reset are sampled one edge after the strobe.

// File: rtl/cm_pkg.sv
package cm_pkg;

    localparam int REG_W  = 8;
    localparam int NREG   = 3;
    localparam int IDX_W  = 2;
    localparam int STEP_W = 4;
    localparam int DEPTH  = 1 << STEP_W;

    typedef enum logic [1:0] {
        OP_STOP = 2'b00,
        OP_INC  = 2'b01,
        OP_DEC  = 2'b10,
        OP_BAD  = 2'b11
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [IDX_W-1:0]  rsel;
        logic [STEP_W-1:0] nxt;
        logic [STEP_W-1:0] alt;
    } step_t;

    localparam int INSTR_W = $bits(step_t);

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_RUN  = 2'b01,
        PH_HALT = 2'b10
    } phase_e;

    function automatic logic step_legal(step_t s);
        if (s.op == OP_BAD) return 1'b0;
        if (s.op == OP_STOP) return 1'b1;
        return (s.rsel != '0) && (int'(s.rsel) <= NREG);
    endfunction

endpackage

// File: rtl/cm_progmem.sv
module cm_progmem
    import cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [STEP_W-1:0] waddr,
    input  step_t             wdata,
    input  logic [STEP_W-1:0] raddr,
    output step_t             rdata,
    output logic              rvalid
);

    step_t            slots [DEPTH];
    logic [DEPTH-1:0] written;
    logic             wr_ok;

    assign wr_ok = we && (waddr != '0);

    always_ff @(posedge clk) begin
        if (wr_ok) slots[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            written <= '0;
        end else if (wr_ok) begin
            written[waddr] <= 1'b1;
        end
    end

    assign rdata  = slots[raddr];
    assign rvalid = written[raddr];

    AST_SLOT0_NEVER_VALID: assert property (@(posedge clk) disable iff (rst)
        (raddr == '0) |-> !rvalid); // R7

endmodule

// File: rtl/cm_regfile.sv
module cm_regfile #(
    parameter int REG_W = 8,
    parameter int NREG  = 3,
    parameter int IDX_W = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ovf_clr,
    input  logic                      preset_en,
    input  logic [IDX_W-1:0]          preset_idx,
    input  logic [REG_W-1:0]          preset_val,
    input  logic                      inc_req,
    input  logic                      dec_req,
    input  logic [IDX_W-1:0]          op_idx,
    output logic [NREG:1][REG_W-1:0]  q,
    output logic                      cur_zero,
    output logic                      ovf
);

    localparam logic [REG_W-1:0] MAXV = '1;

    logic [REG_W-1:0] cur;

    always_comb begin
        cur = '0;
        for (int i = 1; i <= NREG; i++) begin
            if (op_idx == IDX_W'(i)) cur = q[i];
        end
    end

    assign cur_zero = (cur == '0);

    generate
        for (genvar gi = 1; gi <= NREG; gi++) begin : g_cell
            logic [REG_W-1:0] cell_q;
            logic             hit;
            assign hit = (op_idx == IDX_W'(gi));
            always_ff @(posedge clk) begin
                if (rst) begin
                    cell_q <= '0;
                end else if (preset_en && (preset_idx == IDX_W'(gi))) begin
                    cell_q <= preset_val;
                end else if (inc_req && hit && (cell_q != MAXV)) begin
                    cell_q <= cell_q + 1'b1;
                end else if (dec_req && hit && (cell_q != '0)) begin
                    cell_q <= cell_q - 1'b1;
                end
            end
            assign q[gi] = cell_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || ovf_clr) begin
            ovf <= 1'b0;
        end else if (inc_req && (cur == MAXV)) begin
            ovf <= 1'b1;
        end
    end

    AST_INC_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (inc_req && cur == MAXV) |=> (ovf && $stable(q))); // R3
    AST_DEC_ZERO_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (dec_req && cur == '0 && !preset_en) |=> $stable(q)); // R4

endmodule

// File: rtl/cm_sequencer.sv
module cm_sequencer
    import cm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  step_t             instr,
    input  logic              ivalid,
    input  logic              cur_zero,
    output logic [STEP_W-1:0] pc,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [CNT_W-1:0]  step_count,
    output logic              inc_req,
    output logic              dec_req,
    output logic [IDX_W-1:0]  op_idx,
    output logic              ovf_clr
);

    phase_e            phase;
    logic              legal;
    logic              accept;
    logic [STEP_W-1:0] pc_next;

    assign busy    = (phase == PH_RUN);
    assign done    = (phase == PH_HALT);
    assign accept  = start && !busy;
    assign ovf_clr = accept;
    assign legal   = ivalid && step_legal(instr);
    assign op_idx  = instr.rsel;
    assign inc_req = busy && legal && (instr.op == OP_INC);
    assign dec_req = busy && legal && (instr.op == OP_DEC);

    always_comb begin
        pc_next = instr.nxt;
        if ((instr.op == OP_DEC) && cur_zero) pc_next = instr.alt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            pc         <= '0;
            err        <= 1'b0;
            step_count <= '0;
        end else if (accept) begin
            phase      <= PH_RUN;
            pc         <= STEP_W'(1);
            err        <= 1'b0;
            step_count <= '0;
        end else if (busy) begin
            step_count <= step_count + 1'b1;
            if (!legal) begin
                phase <= PH_HALT;
                err   <= 1'b1;
            end else if (instr.op == OP_STOP) begin
                phase <= PH_HALT;
            end else begin
                pc <= pc_next;
            end
        end
    end

    AST_START_AT_STEP1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && pc == STEP_W'(1))); // R5
    AST_COUNT_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> (step_count == $past(step_count) + CNT_W'(1))); // R8
    AST_ERR_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> (done && !busy)); // R7

endmodule

// File: rtl/cm_exec.sv
module cm_exec
    import cm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               prog_we,
    input  logic [STEP_W-1:0]  prog_addr,
    input  logic [INSTR_W-1:0] prog_word,
    input  logic               preset_we,
    input  logic [IDX_W-1:0]   preset_sel,
    input  logic [REG_W-1:0]   preset_val,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               ovf,
    output logic [REG_W-1:0]   reg1,
    output logic [REG_W-1:0]   reg2,
    output logic [REG_W-1:0]   reg3,
    output logic [CNT_W-1:0]   step_count
);

    step_t                     cur_step;
    logic                      cur_valid;
    logic [STEP_W-1:0]         pc;
    logic                      inc_req;
    logic                      dec_req;
    logic [IDX_W-1:0]          op_idx;
    logic                      cur_zero;
    logic                      ovf_clr;
    logic [NREG:1][REG_W-1:0]  regs;

    cm_progmem u_prog (
        .clk    (clk),
        .rst    (rst),
        .we     (prog_we && !busy),
        .waddr  (prog_addr),
        .wdata  (step_t'(prog_word)),
        .raddr  (pc),
        .rdata  (cur_step),
        .rvalid (cur_valid)
    );

    cm_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .instr      (cur_step),
        .ivalid     (cur_valid),
        .cur_zero   (cur_zero),
        .pc         (pc),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .step_count (step_count),
        .inc_req    (inc_req),
        .dec_req    (dec_req),
        .op_idx     (op_idx),
        .ovf_clr    (ovf_clr)
    );

    cm_regfile #(.REG_W(REG_W), .NREG(NREG), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .ovf_clr    (ovf_clr),
        .preset_en  (preset_we && !busy),
        .preset_idx (preset_sel),
        .preset_val (preset_val),
        .inc_req    (inc_req),
        .dec_req    (dec_req),
        .op_idx     (op_idx),
        .q          (regs),
        .cur_zero   (cur_zero),
        .ovf        (ovf)
    );

    assign reg1 = regs[1];
    assign reg2 = regs[2];
    assign reg3 = regs[3];

    AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (done && !start && !preset_we) |=> $stable({reg1, reg2, reg3})); // R6
    AST_BUSY_BLOCKS_PRESET: assert property (@(posedge clk) disable iff (rst)
        (busy && preset_we && !inc_req && !dec_req) |=> $stable({reg1, reg2, reg3})); // R2

endmodule

// File: tb/cm_exec_tb_top.sv
module cm_exec_tb_top;
    import cm_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               prog_we = 1'b0;
    logic [STEP_W-1:0]  prog_addr = '0;
    logic [INSTR_W-1:0] prog_word = '0;
    logic               preset_we = 1'b0;
    logic [IDX_W-1:0]   preset_sel = '0;
    logic [REG_W-1:0]   preset_val = '0;
    logic               start = 1'b0;
    logic               busy, done, err, ovf;
    logic [REG_W-1:0]   reg1, reg2, reg3;
    logic [15:0]        step_count;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cm_exec dut_i (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_word(prog_word), .preset_we(preset_we), .preset_sel(preset_sel),
        .preset_val(preset_val), .start(start), .busy(busy), .done(done),
        .err(err), .ovf(ovf), .reg1(reg1), .reg2(reg2), .reg3(reg3),
        .step_count(step_count)
    );

    localparam logic [1:0] STOP = 2'b00, INC = 2'b01, DEC = 2'b10, BAD = 2'b11;

    function automatic logic [INSTR_W-1:0] mk(logic [1:0] op, int r, int g, int b);
        return {op, 2'(r), 4'(g), 4'(b)};
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load(int a, logic [INSTR_W-1:0] w);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = 4'(a); prog_word = w;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic preset(int idx, int v);
        @(negedge clk);
        preset_we = 1'b1; preset_sel = 2'(idx); preset_val = 8'(v);
        @(negedge clk);
        preset_we = 1'b0;
    endtask

    task automatic set3(int a, int b, int c);
        preset(1, a); preset(2, b); preset(3, c);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(output int cyc);
        pulse_start();
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic load_move();
        load(1, mk(DEC, 3, 1, 2));
        load(2, mk(DEC, 2, 3, 4));
        load(3, mk(INC, 3, 2, 0));
        load(4, mk(STOP, 0, 0, 0));
    endtask

    task automatic load_loop_a();
        load(1, mk(DEC, 2, 2, 3));
        load(2, mk(INC, 1, 1, 0));
        load(3, mk(STOP, 0, 0, 0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 busy", busy, 0);
        chk("R9 done", done, 0);
        chk("R9 err", err, 0);
        chk("R9 ovf", ovf, 0);
        chk("R9 regs", reg1 + reg2 + reg3, 0);
        chk("R9 count", step_count, 0);

        // R10 move program sweep; R4 branch on zero; R8 latency
        load_move();
        for (int n = 0; n <= 12; n++) begin
            for (int mi = 0; mi < 3; mi++) begin
                int m = mi * 4 - (mi == 2 ? 1 : 0);
                set3(55, n, m);
                pulse_start();
                chk("R5 busy after start", busy, 1);
                cyc = 0;
                while (!done && cyc < 5000) begin
                    @(negedge clk);
                    cyc++;
                end
                chk("R10 r2", reg2, 0);
                chk("R10 r3", reg3, n);
                chk("R10 r1", reg1, 55);
                chk("R8 count", step_count, m + 2 * n + 3);
                chk("R8 latency", cyc, m + 2 * n + 3);
                chk("R6 err clear", err, 0);
                chk("R6 busy low", busy, 0);
            end
        end

        // R11 copy program sweep
        load(1, mk(DEC, 3, 1, 2));
        load(2, mk(DEC, 2, 2, 3));
        load(3, mk(DEC, 1, 4, 6));
        load(4, mk(INC, 3, 5, 0));
        load(5, mk(INC, 2, 3, 0));
        load(6, mk(DEC, 2, 7, 8));
        load(7, mk(INC, 1, 6, 0));
        load(8, mk(STOP, 0, 0, 0));
        for (int ai = 0; ai < 8; ai++) begin
            for (int bc = 0; bc < 4; bc++) begin
                int avals[8] = '{0, 1, 2, 5, 17, 40, 100, 255};
                int a = avals[ai];
                int b = (bc & 1) * 4;
                int c = (bc >> 1) * 9;
                set3(a, b, c);
                run(cyc);
                chk("R11 r1", reg1, a);
                chk("R11 r2", reg2, 0);
                chk("R11 r3", reg3, a);
                chk("R11 count", step_count, c + b + 5 * a + 5);
                chk("R8 latency copy", cyc, c + b + 5 * a + 5);
            end
        end

        // R3 saturation and sticky flag
        load_loop_a();
        set3(245, 10, 0);
        run(cyc);
        chk("R3 reach max", reg1, 255);
        chk("R3 no ovf", ovf, 0);
        chk("R8 loop count", step_count, 22);
        set3(250, 10, 0);
        run(cyc);
        chk("R3 saturate", reg1, 255);
        chk("R3 ovf set", ovf, 1);
        set3(0, 1, 0);
        run(cyc);
        chk("R3 ovf cleared on start", ovf, 0);
        chk("R3 inc", reg1, 1);

        // R2 preset and program writes ignored while busy
        set3(0, 30, 0);
        pulse_start();
        preset(1, 200);
        load(3, mk(INC, 1, 0, 0));
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk("R2 preset blocked", reg1, 30);
        chk("R2 write blocked err", err, 0);
        chk("R2 write blocked count", step_count, 62);

        // R2 slot 0 write ignored, R7 jump to step 0
        load(0, mk(INC, 1, 3, 0));
        load(1, mk(INC, 2, 0, 0));
        set3(0, 0, 0);
        run(cyc);
        chk("R7 jump0 err", err, 1);
        chk("R7 jump0 done", done, 1);
        chk("R7 jump0 r2", reg2, 1);
        chk("R2 slot0 ignored r1", reg1, 0);
        chk("R7 jump0 count", step_count, 2);
        chk("R8 jump0 latency", cyc, 2);

        // R9 reset in the middle of a run
        load_loop_a();
        set3(0, 50, 7);
        pulse_start();
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 mid busy", busy, 0);
        chk("R9 mid done", done, 0);
        chk("R9 mid regs", reg1 + reg2 + reg3, 0);
        chk("R9 mid count", step_count, 0);
        run(cyc);
        chk("R9 slots cleared err", err, 1);
        chk("R7 unwritten count", step_count, 1);

        // R7 jump to an unwritten step
        load(1, mk(INC, 1, 9, 0));
        run(cyc);
        chk("R7 unwritten err", err, 1);
        chk("R7 unwritten r1", reg1, 1);
        chk("R7 unwritten count", step_count, 2);

        // R1 illegal opcode and register 0
        load(1, mk(BAD, 1, 1, 1));
        run(cyc);
        chk("R1 bad op err", err, 1);
        chk("R1 bad op count", step_count, 1);
        chk("R1 bad op r1", reg1, 1);
        load(1, mk(INC, 0, 1, 1));
        run(cyc);
        chk("R1 reg0 err", err, 1);
        chk("R1 reg0 count", step_count, 1);
        chk("R1 reg0 regs", reg1 + reg2 + reg3, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule